// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter with a selectable count source, a power-of-two prescaler and a gate unit that decides when counting is allowed. The count source can be the system clock, the instruction rate (system clock divided by four) or an external count pin. In every mode the counter runs only while the enable input is high. When it wraps from FFFFh to 0000h it sets a sticky overflow flag.

The gate unit takes one of three trigger sources: a gate pin, a timer0 overflow pulse or a timer2 period-match pulse. It can invert the selected source, or turn it into a toggled window in which each rising edge opens or closes the window. In single-pulse mode, software sets GO and the counter then measures exactly one window. The single-pulse state machine has three states:
- SP_IDLE: GO is clear (DONE).
- SP_ARMED: GO is set and the unit waits for a window rising edge.
- SP_PULSE: the window is open and the counter is counting.

The transitions are:
- SP_IDLE to SP_ARMED on a GO request.
- SP_ARMED to SP_PULSE on a window rising edge.
- SP_PULSE to SP_IDLE on a window falling edge. This is the completion, and it also raises the gate event flag.
- Any state to SP_IDLE when single-pulse mode or gating is switched off.

Software loads the count one byte at a time through a small write port. Any count write also restarts the prescaler and the instruction-rate divider.

Top module: `gated_timer16`

## Requirements
- R1: After reset, `count` is 0000h, `ovf_flag`, `gate_flag` and `go_busy` are 0, and the single-pulse machine is in SP_IDLE.
- R2: `clk_sel` = 01 advances the prescaler on every enabled system clock cycle. `clk_sel` = 00 advances it once every 4 enabled cycles. `clk_sel` = 11 produces no count.
- R3: `clk_sel` = 10 counts rising edges of `ext_clk`. A rising edge counts only if at least one falling edge of `ext_clk` has been seen since `en` last went high.
- R4: `pre_sel` values 0, 1, 2 and 3 divide the selected source by 1, 2, 4 and 8. The first increment comes after the full division count.
- R5: `ext_sync` = 1 samples `ext_clk` through two flops, and `ext_sync` = 0 samples it through one flop. Every qualified edge is counted in both settings.
- R6: While `en` is 0, `count` and the prescaler hold their values.
- R7: A write with `wr_hi` = 0 loads `wr_data` into count bits 7:0, and a write with `wr_hi` = 1 loads bits 15:8. Every write clears the prescaler and the divider. A write takes priority over an increment in the same cycle.
- R8: An increment from FFFFh to 0000h sets `ovf_flag`. The flag stays set until an `ovf_clr` pulse, and a set in the same cycle wins over the clear.
- R9: With `gate_en` = 1, the counter advances only while the gate window is high. At each window falling edge outside single-pulse mode, `gate_flag` is set and stays set until `gif_clr`. With `gate_en` = 0 the gate has no effect.
- R10: `gate_src` selects the gate source: 00 is the synchronized `gate_pin`, 01 is `t0_ovf`, 10 is `t2_match`, and 11 also selects the pin. `gate_pol` = 1 inverts the selected source before it is used.
- R11: With `gate_tgl` = 1, each rising edge of the conditioned gate flips an internal flop, and the window follows that flop. The flop is cleared while `gate_tgl` = 0.
- R12: With `gate_spm` = 1 and `gate_en` = 1, a `go_set` pulse sets `go_busy`. The counter then counts during the next complete window only. At that window's falling edge `go_busy` clears and `gate_flag` is set. Later windows do not count until GO is set again.
- R13: `gate_level` shows the current gate window, after source selection, polarity and toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter enable |
| clk_sel | input | 2 | Count source select |
| pre_sel | input | 2 | Prescale select (divide by 2^pre_sel) |
| ext_sync | input | 1 | Two-stage external sampling when high |
| ext_clk | input | 1 | External count input |
| gate_pin | input | 1 | External gate input |
| t0_ovf | input | 1 | Timer0 overflow pulse |
| t2_match | input | 1 | Timer2 period-match pulse |
| gate_en | input | 1 | Gate control enable |
| gate_pol | input | 1 | Invert gate source |
| gate_tgl | input | 1 | Gate toggle mode |
| gate_spm | input | 1 | Single-pulse mode |
| gate_src | input | 2 | Gate source select |
| go_set | input | 1 | Pulse that sets GO |
| wr_en | input | 1 | Count byte write strobe |
| wr_hi | input | 1 | Write high byte when 1, low byte when 0 |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Clear overflow flag |
| gif_clr | input | 1 | Clear gate flag |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Overflow interrupt flag |
| gate_flag | output | 1 | Gate event interrupt flag |
| gate_level | output | 1 | Current gate window level |
| go_busy | output | 1 | GO bit (0 means DONE) |

## Verification
The hardest case to reach from the ports is a single-pulse acquisition that must ignore a window already open when GO is set, count the next window in full, and then ignore every window after it. The stimulus reaches this case in steps. It keeps the gate pin low, pulses `go_set`, and checks that GO is pending. It then drives one pin pulse of known length and checks the count, DONE and the gate flag. Finally it drives a second pulse and checks that the count has not moved. A second hard case is the external edge qualification. The stimulus enables the counter while `ext_clk` is low and checks that the first rising edge is dropped. It repeats the run with the pin high at enable, so that the first edge seen is a falling one.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    typedef enum logic [1:0] {
        CS_INSTR = 2'b00,
        CS_SYS   = 2'b01,
        CS_EXT   = 2'b10,
        CS_NONE  = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        GS_PIN   = 2'b00,
        GS_T0    = 2'b01,
        GS_T2    = 2'b10,
        GS_PIN_B = 2'b11
    } gate_src_e;

    typedef enum logic [1:0] {
        SP_IDLE  = 2'b00,
        SP_ARMED = 2'b01,
        SP_PULSE = 2'b10
    } sp_state_e;

endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d,
    output logic [STAGES-1:0] taps
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) taps[0] <= 1'b0;
                else        taps[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) taps[i] <= 1'b0;
                else        taps[i] <= taps[i-1];
            end
        end
    end
endmodule

// File: rtl/gtmr_tick.sv
module gtmr_tick
    import gtmr_pkg::*;
#(
    parameter int PS_W   = 2,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            run,
    input  logic [1:0]      clk_sel,
    input  logic [PS_W-1:0] pre_sel,
    input  logic            ext_sync,
    input  logic            ext_clk,
    input  logic            clr,
    output logic            cnt_tick
);
    localparam int PC_W  = (1 << PS_W) - 1;
    localparam int DIV_W = 2;

    logic [SYNC_N-1:0] ext_taps;
    logic              ext_s, ext_q, armed;
    logic              ext_rise, ext_fall, ext_tick;
    logic [DIV_W-1:0]  div_q;
    logic              src_tick, pre_in;
    logic [PC_W-1:0]   pcnt, lim;

    gtmr_sync #(.STAGES(SYNC_N)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ext_clk),
        .taps (ext_taps)
    );

    assign ext_s    = ext_sync ? ext_taps[SYNC_N-1] : ext_taps[0];
    assign ext_rise = ext_s & ~ext_q;
    assign ext_fall = ~ext_s & ext_q;
    assign ext_tick = ext_rise & armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            armed <= 1'b0;
        end else begin
            ext_q <= ext_s;
            if (!en)          armed <= 1'b0;
            else if (ext_fall) armed <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   div_q <= '0;
        else if (clr) div_q <= '0;
        else if (run) div_q <= div_q + 1'b1;
    end

    always_comb begin
        unique case (clk_src_e'(clk_sel))
            CS_INSTR: src_tick = (div_q == {DIV_W{1'b1}});
            CS_SYS:   src_tick = 1'b1;
            CS_EXT:   src_tick = ext_tick;
            CS_NONE:  src_tick = 1'b0;
        endcase
    end

    assign pre_in = src_tick & run;
    assign lim    = PC_W'(({{PC_W{1'b0}}, 1'b1} << pre_sel) - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt <= '0;
        else if (clr)    pcnt <= '0;
        else if (pre_in) pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
    end

    assign cnt_tick = pre_in & (pcnt >= lim) & ~clr;

    // R4: after a prescaled tick the next enabled source tick cannot also emit
    p_prescale_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && pre_sel != '0 && $stable(pre_sel)) |=> (!cnt_tick || !$stable(pre_sel) || clr));

    // R3: no count from the external pin before a falling edge has armed it
    p_ext_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b10 && !armed && !ext_fall) |=> !cnt_tick);
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate
    import gtmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_pin,
    input  logic       t0_ovf,
    input  logic       t2_match,
    input  logic [1:0] gate_src,
    input  logic       gate_pol,
    input  logic       gate_tgl,
    input  logic       gate_spm,
    input  logic       gate_en,
    input  logic       go_set,
    output logic       window,
    output logic       open,
    output logic       gate_evt,
    output logic       busy
);
    logic [SYNC_N-1:0] pin_taps;
    logic              raw, g, g_q, g_rise, tflop, win_q, win_rise, win_fall;
    sp_state_e         state_q, state_d;

    gtmr_sync #(.STAGES(SYNC_N)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (gate_pin),
        .taps (pin_taps)
    );

    always_comb begin
        unique case (gate_src_e'(gate_src))
            GS_PIN, GS_PIN_B: raw = pin_taps[SYNC_N-1];
            GS_T0:            raw = t0_ovf;
            GS_T2:            raw = t2_match;
        endcase
    end

    assign g        = raw ^ gate_pol;
    assign g_rise   = g & ~g_q;
    assign window   = gate_tgl ? tflop : g;
    assign win_rise = window & ~win_q;
    assign win_fall = ~window & win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q   <= 1'b0;
            tflop <= 1'b0;
            win_q <= 1'b0;
        end else begin
            g_q   <= g;
            win_q <= window;
            if (!gate_tgl)   tflop <= 1'b0;
            else if (g_rise) tflop <= ~tflop;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SP_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SP_IDLE:  if (gate_spm && gate_en && go_set) state_d = SP_ARMED;
            SP_ARMED: if (!gate_spm || !gate_en)         state_d = SP_IDLE;
                      else if (win_rise)                 state_d = SP_PULSE;
            SP_PULSE: if (!gate_spm || !gate_en || win_fall) state_d = SP_IDLE;
            default:  state_d = SP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != SP_IDLE);
        open     = 1'b1;
        gate_evt = 1'b0;
        if (gate_en) begin
            if (gate_spm) begin
                open     = window & ((state_q == SP_PULSE) | ((state_q == SP_ARMED) & win_rise));
                gate_evt = win_fall & (state_q == SP_PULSE);
            end else begin
                open     = window;
                gate_evt = win_fall;
            end
        end
    end

    // R12: completion of an acquisition returns the machine to DONE
    p_done_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SP_PULSE && win_fall) |=> (state_q == SP_IDLE));

    // R12: GO cannot stay pending outside single-pulse mode
    p_idle_without_spm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_spm) |=> (state_q == SP_IDLE));
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import gtmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 2,
    parameter int SYNC_N = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [1:0]  clk_sel,
    input  logic [1:0]  pre_sel,
    input  logic        ext_sync,
    input  logic        ext_clk,
    input  logic        gate_pin,
    input  logic        t0_ovf,
    input  logic        t2_match,
    input  logic        gate_en,
    input  logic        gate_pol,
    input  logic        gate_tgl,
    input  logic        gate_spm,
    input  logic [1:0]  gate_src,
    input  logic        go_set,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [7:0]  wr_data,
    input  logic        ovf_clr,
    input  logic        gif_clr,
    output logic [15:0] count,
    output logic        ovf_flag,
    output logic        gate_flag,
    output logic        gate_level,
    output logic        go_busy
);
    localparam int BYTE_W = 8;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             open, gate_evt, cnt_tick, run;
    logic [CNT_W-1:0] cnt_q;

    gtmr_gate #(.SYNC_N(SYNC_N)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_pin(gate_pin),
        .t0_ovf  (t0_ovf),
        .t2_match(t2_match),
        .gate_src(gate_src),
        .gate_pol(gate_pol),
        .gate_tgl(gate_tgl),
        .gate_spm(gate_spm),
        .gate_en (gate_en),
        .go_set  (go_set),
        .window  (gate_level),
        .open    (open),
        .gate_evt(gate_evt),
        .busy    (go_busy)
    );

    assign run = en & open;

    gtmr_tick #(.PS_W(PS_W), .SYNC_N(SYNC_N)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .run     (run),
        .clk_sel (clk_sel),
        .pre_sel (pre_sel[PS_W-1:0]),
        .ext_sync(ext_sync),
        .ext_clk (ext_clk),
        .clr     (wr_en),
        .cnt_tick(cnt_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            if (wr_hi) cnt_q[2*BYTE_W-1:BYTE_W] <= wr_data;
            else       cnt_q[BYTE_W-1:0]        <= wr_data;
        end else if (cnt_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag  <= 1'b0;
            gate_flag <= 1'b0;
        end else begin
            if (cnt_tick && !wr_en && cnt_q == CNT_MAX) ovf_flag <= 1'b1;
            else if (ovf_clr)                           ovf_flag <= 1'b0;
            if (gate_evt)     gate_flag <= 1'b1;
            else if (gif_clr) gate_flag <= 1'b0;
        end
    end

    assign count = cnt_q[15:0];

    // R8: a wrap raises the overflow flag and leaves zero
    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_en && count == 16'hFFFF) |=> (ovf_flag && count == 16'h0000));

    // R6: disabled counter holds
    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> $stable(count));

    // R9: a closed gate window blocks every prescaled tick
    p_gate_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !gate_level) |-> !cnt_tick);
endmodule

// File: tb/sim_gated_timer16.sv
`timescale 1ns/1ps
module sim_gated_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 0, ext_sync = 0, ext_clk = 0, gate_pin = 0, t0_ovf = 0, t2_match = 0;
    logic [1:0]  clk_sel = 2'b01, pre_sel = 2'b00, gate_src = 2'b00;
    logic        gate_en = 0, gate_pol = 0, gate_tgl = 0, gate_spm = 0, go_set = 0;
    logic        wr_en = 0, wr_hi = 0, ovf_clr = 0, gif_clr = 0;
    logic [7:0]  wr_data = 0;
    logic [15:0] count;
    logic        ovf_flag, gate_flag, gate_level, go_busy;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    gated_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel), .pre_sel(pre_sel),
        .ext_sync(ext_sync), .ext_clk(ext_clk), .gate_pin(gate_pin), .t0_ovf(t0_ovf),
        .t2_match(t2_match), .gate_en(gate_en), .gate_pol(gate_pol), .gate_tgl(gate_tgl),
        .gate_spm(gate_spm), .gate_src(gate_src), .go_set(go_set), .wr_en(wr_en),
        .wr_hi(wr_hi), .wr_data(wr_data), .ovf_clr(ovf_clr), .gif_clr(gif_clr),
        .count(count), .ovf_flag(ovf_flag), .gate_flag(gate_flag),
        .gate_level(gate_level), .go_busy(go_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write16(input logic [15:0] v);
        @(negedge clk); wr_en = 1; wr_hi = 0; wr_data = v[7:0];
        @(negedge clk); wr_hi = 1; wr_data = v[15:8];
        @(negedge clk); wr_en = 0; wr_hi = 0;
    endtask

    task automatic run(input int n);
        en = 1; cycles(n); en = 0;
    endtask

    task automatic pulse_gif_clr();
        gif_clr = 1; cycles(1); gif_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 count", count, 0);
        check("R1 ovf_flag", ovf_flag, 0);
        check("R1 gate_flag", gate_flag, 0);
        check("R1 go_busy", go_busy, 0);
    endtask

    task automatic t_sys_prescale();
        clk_sel = 2'b01;
        for (int ps = 0; ps < 4; ps++) begin
            pre_sel = 2'(ps);
            write16(16'h0000);
            run(40);
            check($sformatf("R4 R2 sysclk ps=%0d", ps), count, 40 >> ps);
        end
        pre_sel = 0;
    endtask

    task automatic t_instr();
        clk_sel = 2'b00; pre_sel = 0;
        write16(0); run(40);
        check("R2 instr div4", count, 10);
        pre_sel = 1; write16(0); run(80);
        check("R2 R4 instr ps2", count, 10);
        clk_sel = 2'b11; pre_sel = 0; write16(0); run(20);
        check("R2 source 11 idle", count, 0);
        clk_sel = 2'b01;
    endtask

    task automatic t_hold();
        write16(16'h0005); cycles(10);
        check("R6 hold while disabled", count, 5);
    endtask

    task automatic t_write();
        write16(16'h1234);
        check("R7 byte write", count, 16'h1234);
        pre_sel = 3; write16(0); run(6);
        cycles(1); wr_en = 1; wr_hi = 0; wr_data = 0; cycles(1); wr_en = 0;
        run(4);
        check("R7 write clears prescaler", count, 0);
        run(4);
        check("R7 R4 count after full divide", count, 1);
        // write and increment in same cycle: write wins
        pre_sel = 0; write16(16'h00F0);
        en = 1; wr_en = 1; wr_hi = 0; wr_data = 8'h10; cycles(1); wr_en = 0; en = 0;
        check("R7 write over increment", count, 16'h0010);
    endtask

    task automatic t_overflow();
        clk_sel = 2'b01; pre_sel = 0;
        write16(16'hFFFE); run(1);
        check("R8 no flag before wrap", ovf_flag, 0);
        run(1);
        check("R8 wrap value", count, 0);
        check("R8 flag set", ovf_flag, 1);
        cycles(3);
        check("R8 flag sticky", ovf_flag, 1);
        ovf_clr = 1; cycles(1); ovf_clr = 0;
        check("R8 flag cleared", ovf_flag, 0);
    endtask

    task automatic ext_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            ext_clk = 1; cycles(3); ext_clk = 0; cycles(3);
        end
    endtask

    task automatic t_external();
        clk_sel = 2'b10; pre_sel = 0;
        for (int s = 0; s < 2; s++) begin
            ext_sync = s[0];
            ext_clk = 0; write16(0);
            en = 1; ext_pulses(5); cycles(4); en = 0;
            check($sformatf("R3 R5 first rise dropped sync=%0d", s), count, 4);
        end
        ext_clk = 1; cycles(4); write16(0);
        en = 1; cycles(2); ext_clk = 0; cycles(3); ext_pulses(3); cycles(4); en = 0;
        check("R3 armed by fall", count, 3);
        pre_sel = 1; ext_clk = 0; write16(0);
        en = 1; ext_pulses(7); cycles(4); en = 0;
        check("R4 R3 ext ps2", count, 3);
        pre_sel = 0; ext_sync = 0; clk_sel = 2'b01;
    endtask

    task automatic t_gate_pin();
        clk_sel = 2'b01; pre_sel = 0; gate_en = 1; gate_src = 2'b00; gate_pol = 0;
        gate_pin = 0; cycles(4); pulse_gif_clr(); write16(0);
        en = 1; cycles(3); gate_pin = 1; cycles(4);
        check("R13 gate_level open", gate_level, 1);
        cycles(6); gate_pin = 0; cycles(5);
        check("R13 gate_level closed", gate_level, 0);
        en = 0;
        check("R9 count within window", count, 10);
        check("R9 gate flag on window end", gate_flag, 1);
        gate_pol = 1; gate_pin = 1; cycles(4); write16(0);
        en = 1; cycles(3); gate_pin = 0; cycles(7); gate_pin = 1; cycles(5); en = 0;
        check("R10 inverted polarity", count, 7);
        gate_pol = 0; gate_pin = 0;
        gate_en = 0; write16(0); run(20);
        check("R9 gate ignored when off", count, 20);
        gate_en = 1;
    endtask

    task automatic t_gate_sources();
        gate_en = 1; gate_pol = 0; gate_pin = 1;
        gate_src = 2'b01; write16(0); en = 1;
        for (int i = 0; i < 3; i++) begin
            cycles(3); t0_ovf = 1; cycles(1); t0_ovf = 0;
        end
        cycles(3); en = 0;
        check("R10 timer0 source", count, 3);
        gate_src = 2'b10; write16(0); en = 1;
        for (int i = 0; i < 2; i++) begin
            cycles(3); t2_match = 1; cycles(1); t2_match = 0;
        end
        cycles(3); en = 0;
        check("R10 timer2 source", count, 2);
        gate_pin = 0; gate_src = 2'b11; cycles(4); write16(0);
        en = 1; cycles(2); gate_pin = 1; cycles(6); gate_pin = 0; cycles(5); en = 0;
        check("R10 code 11 uses pin", count, 6);
        gate_src = 2'b00;
    endtask

    task automatic t_toggle();
        gate_en = 1; gate_tgl = 1; gate_pin = 0; cycles(4); write16(0);
        en = 1; cycles(2);
        gate_pin = 1; cycles(1); gate_pin = 0; cycles(11);
        gate_pin = 1; cycles(1); gate_pin = 0; cycles(8);
        en = 0;
        check("R11 toggle window", count, 12);
        check("R11 window closed after second edge", gate_level, 0);
        gate_tgl = 0;
    endtask

    task automatic t_single_pulse();
        gate_en = 1; gate_spm = 1; gate_pin = 0; cycles(4);
        pulse_gif_clr(); write16(0);
        en = 1;
        go_set = 1; cycles(1); go_set = 0;
        check("R12 GO pending", go_busy, 1);
        cycles(3);
        gate_pin = 1; cycles(8); gate_pin = 0; cycles(6);
        check("R12 one window counted", count, 8);
        check("R12 DONE", go_busy, 0);
        check("R12 gate flag at completion", gate_flag, 1);
        gate_pin = 1; cycles(5); gate_pin = 0; cycles(6);
        en = 0;
        check("R12 later window ignored", count, 8);
        gate_spm = 0; gate_en = 0;
    endtask

    initial begin
        cycles(3);
        rst_n = 1;
        cycles(2);
        t_reset();
        t_sys_prescale();
        t_instr();
        t_hold();
        t_write();
        t_overflow();
        t_external();
        t_gate_pin();
        t_gate_sources();
        t_toggle();
        t_single_pulse();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule